// File: doc/BRIEF.md
# Striped Interrupt Vector Router

The router keeps one pending bit and one enable bit for each of 256 interrupt vectors. It folds the vectors that are both pending and enabled onto four interrupt lines. Software picks one of three stripe patterns, which decides the line each vector reaches. Another writable setting chooses whether the four lines appear on outputs 0–3 (low link half) or on outputs 4–7 (high link half).

Vectors are raised in two ways. The first is a one-cycle vector set port that carries an 8-bit vector number. The second is seven legacy level inputs, packed into one 8-vector group whose 5-bit group index comes from the control register. Software reads pending and enable words through a simple register port. It writes enable words directly and clears pending bits by writing ones.

Top module: `irq_stripe_router`

## Requirements
- R1: After reset all pending bits, all enable bits and the control register read as zero, and all eight line outputs are low.
- R2: A cycle with `setValid` high sets the pending bit of vector `setIdx` at the next clock edge. Pending word k is read at address k (0–7) and holds vector 32k+b in bit b.
- R3: Writing a pending word (addresses 0–7) clears each pending bit whose data bit is one and leaves the others alone. When a set and a clear hit the same bit in one cycle, the bit stays set.
- R4: Enable word k is written and read at address 8+k, with vector 32k+b in bit b. A line output is the OR of all vectors routed to it that are both pending and enabled, so a pending vector whose enable bit is zero drives no line.
- R5: With control bits [1:0] = 0 (contiguous), vector v drives line v[7:6].
- R6: With control bits [1:0] = 1 (interleave by 2), vector v drives line {v[7], v[0]}.
- R7: With control bits [1:0] = 2 (interleave by 4), vector v drives line v[1:0].
- R8: With control bits [1:0] = 3, routing is identical to mode 0.
- R9: With control bit 2 at zero, line n drives output n and outputs 7–4 stay low. With control bit 2 at one, line n drives output 4+n and outputs 3–0 stay low.
- R10: While a legacy input is high, the pending bit of vector {idx, pos} is set, where idx is control bits [28:24]. The positions are SMI 0, NMI 1, INIT 2, INTA 4, INTB 5, INTC 6 and INTD 7. Position 3 is never set by this path.
- R11: The control register sits at address 16 and reads back bits [1:0], [2] and [28:24] as written, with all other bits zero. Addresses 17–31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Vector set strobe |
| setIdx | input | 8 | Vector number to set |
| smiIn | input | 1 | Legacy level, group position 0 |
| nmiIn | input | 1 | Legacy level, group position 1 |
| initIn | input | 1 | Legacy level, group position 2 |
| intaIn | input | 1 | Legacy level, group position 4 |
| intbIn | input | 1 | Legacy level, group position 5 |
| intcIn | input | 1 | Legacy level, group position 6 |
| intdIn | input | 1 | Legacy level, group position 7 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| intLine | output | 8 | Interrupt line outputs |

## Verification
The bench builds the block with its default sizes: 256 vectors, four lines per half and 32-bit register words. At these sizes every stripe boundary can be reached with single vectors: 63/64, 127/128 and 191/192, plus 0 and 255. All four mode codes and both halves are used. A legacy group index in the middle of the range lets the check confirm that legacy bits land in the expected pending word and bit. Same-cycle set and clear, and a pending vector whose enable bit is zero, are driven directly at the ports.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int VEC_NUM = 256;
  localparam int REG_W   = 32;
  localparam int LINES   = 4;
  localparam int GRP     = 8;
  localparam int LEG_LSB = 24;
  localparam int WORDS   = VEC_NUM / REG_W;
  localparam int WORD_AW = $clog2(WORDS);
  localparam int VEC_AW  = $clog2(VEC_NUM);
  localparam int GRP_AW  = $clog2(GRP);
  localparam int IDX_W   = VEC_AW - GRP_AW;
  localparam int ADDR_W  = WORD_AW + 2;
  localparam int BIT_AW  = $clog2(REG_W);

  typedef enum logic [1:0] {
    MODE_S1  = 2'd0,
    MODE_S2  = 2'd1,
    MODE_S4  = 2'd2,
    MODE_RSV = 2'd3
  } stripe_e;

  typedef struct packed {
    logic                pendClr;
    logic                enWr;
    logic [WORD_AW-1:0]  word;
    logic [REG_W-1:0]    data;
  } strobe_t;

  typedef struct packed {
    stripe_e             mode;
    logic                highHalf;
    logic [IDX_W-1:0]    legIdx;
  } cfg_t;

  function automatic logic [REG_W-1:0] packCfg(cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[1:0] = c.mode;
    r[2] = c.highHalf;
    r[LEG_LSB +: IDX_W] = c.legIdx;
    return r;
  endfunction

  function automatic cfg_t unpackCfg(logic [REG_W-1:0] w);
    cfg_t c;
    c.mode = stripe_e'(w[1:0]);
    c.highHalf = w[2];
    c.legIdx = w[LEG_LSB +: IDX_W];
    return c;
  endfunction

  function automatic int lineOf(int v, stripe_e m);
    case (m)
      MODE_S2: return (v / (VEC_NUM / 2)) * 2 + (v % 2);
      MODE_S4: return v % LINES;
      default: return v / (VEC_NUM / LINES);
    endcase
  endfunction

  function automatic logic [VEC_NUM-1:0] routeMask(stripe_e m, int line);
    logic [VEC_NUM-1:0] r;
    for (int v = 0; v < VEC_NUM; v++) r[v] = (lineOf(v, m) == line);
    return r;
  endfunction
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output strobe_t           strobe,
  output cfg_t              cfg
);
  logic [1:0]         region;
  logic [WORD_AW-1:0] word;
  logic               ctrlWr;
  cfg_t               cfgQ;

  assign region = regAddr[ADDR_W-1:WORD_AW];
  assign word   = regAddr[WORD_AW-1:0];

  always_comb begin
    strobe.pendClr = regWrEn && (region == 2'd0);
    strobe.enWr    = regWrEn && (region == 2'd1);
    strobe.word    = word;
    strobe.data    = regWdata;
    ctrlWr         = regWrEn && (region == 2'd2) && (word == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (ctrlWr) cfgQ <= unpackCfg(regWdata);
  end

  assign cfg = cfgQ;

  // R11: a control write is visible on the next cycle
  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (packCfg(cfg) == packCfg(unpackCfg($past(regWdata)))));

  // R11: without a control write the configuration holds
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(cfg));
endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  cfg_t               cfg,
  input  logic               setValid,
  input  logic [VEC_AW-1:0]  setIdx,
  input  logic [GRP-1:0]     legacyVec,
  input  logic [ADDR_W-1:0]  regAddr,
  output logic [REG_W-1:0]   regRdata,
  output logic [VEC_NUM-1:0] activeVec
);
  logic [VEC_NUM-1:0] pendQ, enQ, pendD, enD;
  logic [VEC_NUM-1:0] setMask, clrMask, legMask;
  logic [1:0]         rdRegion;
  logic [WORD_AW-1:0] rdWord;

  generate
    for (genvar v = 0; v < VEC_NUM; v++) begin : g_vec
      localparam int               WordOf = v / REG_W;
      localparam int               BitOf  = v % REG_W;
      localparam int               PosOf  = v % GRP;
      localparam logic [IDX_W-1:0] GrpOf  = IDX_W'(v / GRP);
      assign setMask[v] = setValid && (setIdx == VEC_AW'(v));
      assign clrMask[v] = strobe.pendClr && (strobe.word == WORD_AW'(WordOf))
                          && strobe.data[BitOf];
      assign legMask[v] = legacyVec[PosOf] && (cfg.legIdx == GrpOf);
      assign enD[v]     = (strobe.enWr && (strobe.word == WORD_AW'(WordOf)))
                          ? strobe.data[BitOf] : enQ[v];
    end
  endgenerate

  // setting has priority over a same-cycle clear
  assign pendD = (pendQ & ~clrMask) | setMask | legMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
    end else begin
      pendQ <= pendD;
      enQ   <= enD;
    end
  end

  assign activeVec = pendQ & enQ;

  assign rdRegion = regAddr[ADDR_W-1:WORD_AW];
  assign rdWord   = regAddr[WORD_AW-1:0];

  always_comb begin
    case (rdRegion)
      2'd0:    regRdata = pendQ[int'(rdWord) * REG_W +: REG_W];
      2'd1:    regRdata = enQ[int'(rdWord) * REG_W +: REG_W];
      2'd2:    regRdata = (rdWord == '0) ? packCfg(cfg) : '0;
      default: regRdata = '0;
    endcase
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    setValid |=> pendQ[$past(setIdx)]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && strobe.pendClr && (strobe.word == setIdx[VEC_AW-1:BIT_AW])
     && strobe.data[setIdx[BIT_AW-1:0]]) |=> pendQ[$past(setIdx)]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pendClr && !setValid && (legacyVec == '0))
    |=> ((pendQ[int'($past(strobe.word)) * REG_W +: REG_W] & $past(strobe.data)) == '0));

  p_legacy_smi_r10: assert property (@(posedge clk) disable iff (!rstN)
    legacyVec[0] |=> pendQ[{$past(cfg.legIdx), {GRP_AW{1'b0}}}]);
endmodule

// File: rtl/isr_route.sv
module isr_route
  import isr_pkg::*;
(
  input  logic [VEC_NUM-1:0]   activeVec,
  input  stripe_e              mode,
  input  logic                 highHalf,
  output logic [2*LINES-1:0]   lines
);
  logic [LINES-1:0] hit;

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      localparam logic [VEC_NUM-1:0] MaskS1 = routeMask(MODE_S1, l);
      localparam logic [VEC_NUM-1:0] MaskS2 = routeMask(MODE_S2, l);
      localparam logic [VEC_NUM-1:0] MaskS4 = routeMask(MODE_S4, l);
      always_comb begin
        case (mode)
          MODE_S2: hit[l] = |(activeVec & MaskS2);
          MODE_S4: hit[l] = |(activeVec & MaskS4);
          default: hit[l] = |(activeVec & MaskS1);
        endcase
      end
    end
  endgenerate

  assign lines = highHalf ? {hit, {LINES{1'b0}}} : {{LINES{1'b0}}, hit};
endmodule

// File: rtl/irq_stripe_router.sv
module irq_stripe_router
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [VEC_AW-1:0] setIdx,
  input  logic              smiIn,
  input  logic              nmiIn,
  input  logic              initIn,
  input  logic              intaIn,
  input  logic              intbIn,
  input  logic              intcIn,
  input  logic              intdIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [2*LINES-1:0] intLine
);
  strobe_t            strobe;
  cfg_t               cfg;
  logic [GRP-1:0]     legacyVec;
  logic [VEC_NUM-1:0] activeVec;

  // group positions 7..0: INTD INTC INTB INTA unused INIT NMI SMI
  assign legacyVec = {intdIn, intcIn, intbIn, intaIn, 1'b0, initIn, nmiIn, smiIn};

  isr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .cfg(cfg)
  );

  isr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg),
    .setValid(setValid), .setIdx(setIdx), .legacyVec(legacyVec),
    .regAddr(regAddr), .regRdata(regRdata), .activeVec(activeVec)
  );

  isr_route u_route (
    .activeVec(activeVec), .mode(cfg.mode), .highHalf(cfg.highHalf),
    .lines(intLine)
  );

  p_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec == '0) |-> (intLine == '0));

  p_half_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.highHalf |-> (intLine[2*LINES-1:LINES] == '0));

  p_half_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfg.highHalf |-> (intLine[LINES-1:0] == '0));

  p_one_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(activeVec) == 1) |-> ($countones(intLine) == 1));
endmodule

// File: tb/irq_stripe_router_tb_top.sv
`timescale 1ns/1ps
module irq_stripe_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setValid = 1'b0;
  logic [7:0]  setIdx = '0;
  logic        smiIn = 0, nmiIn = 0, initIn = 0, intaIn = 0, intbIn = 0, intcIn = 0, intdIn = 0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  intLine;

  irq_stripe_router dut_i (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setIdx(setIdx),
    .smiIn(smiIn), .nmiIn(nmiIn), .initIn(initIn), .intaIn(intaIn),
    .intbIn(intbIn), .intcIn(intcIn), .intdIn(intdIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .intLine(intLine)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit          isLine;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // monitor: pops expectations and compares against the ports
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      act = it.isLine ? {24'd0, intLine} : regRdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expectLine(logic [7:0] exp, string tag);
    item_t it;
    it.isLine = 1; it.exp = {24'd0, exp}; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expectRead(logic [4:0] addr, logic [31:0] exp, string tag);
    item_t it;
    regAddr = addr;
    it.isLine = 0; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic regWrite(logic [4:0] addr, logic [31:0] data);
    regWrEn = 1; regAddr = addr; regWdata = data;
    tick();
    regWrEn = 0; regWdata = '0;
  endtask

  task automatic setVec(int v);
    setValid = 1; setIdx = 8'(v);
    tick();
    setValid = 0;
  endtask

  task automatic clearVec(int v);
    regWrite(5'(v / 32), 32'd1 << (v % 32));
  endtask

  function automatic int expLine(logic [7:0] v, int mode);
    case (mode)
      1: return int'({v[7], v[0]});
      2: return int'(v[1:0]);
      default: return int'(v[7:6]);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  int vecList[12] = '{0, 1, 2, 3, 63, 64, 127, 128, 129, 191, 192, 255};

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;

    // R1 reset state
    expectRead(5'd16, 32'h0, "R1 control after reset");
    expectRead(5'd0, 32'h0, "R1 pending word 0 after reset");
    expectRead(5'd15, 32'h0, "R1 enable word 7 after reset");
    expectLine(8'h00, "R1 lines after reset");

    // R4 enable all and read back
    for (int w = 0; w < 8; w++) regWrite(5'(8 + w), 32'hFFFF_FFFF);
    expectRead(5'd11, 32'hFFFF_FFFF, "R4 enable word readback");

    // R5 R6 R7 R8 each stripe mode over the boundaries
    for (int m = 0; m < 4; m++) begin
      regWrite(5'd16, 32'(m));
      expectRead(5'd16, 32'(m), "R11 mode readback");
      foreach (vecList[i]) begin
        int v;
        v = vecList[i];
        setVec(v);
        expectLine(8'd1 << expLine(8'(v), m),
          m == 0 ? "R5 contiguous" : m == 1 ? "R6 interleave2" :
          m == 2 ? "R7 interleave4" : "R8 mode3 as contiguous");
        clearVec(v);
        expectLine(8'h00, "R3 line drops after clear");
      end
    end

    // R2 multiple pending, R4 OR of vectors
    regWrite(5'd16, 32'd2);
    setVec(4); setVec(9);
    expectRead(5'd0, 32'h0000_0210, "R2 pending word 0 holds vectors 4 and 9");
    expectLine(8'h03, "R4 two lines from two vectors");
    clearVec(4);
    expectRead(5'd0, 32'h0000_0200, "R3 selective clear keeps vector 9");
    clearVec(9);

    // R4 disabled vector drives nothing
    regWrite(5'd8, 32'h0);
    setVec(5);
    expectRead(5'd0, 32'h0000_0020, "R4 disabled vector still pending");
    expectLine(8'h00, "R4 disabled vector no line");
    regWrite(5'd8, 32'h0000_0020);
    expectLine(8'h02, "R4 enabling routes pending vector");
    clearVec(5);
    regWrite(5'd8, 32'hFFFF_FFFF);

    // R3 set and clear in same cycle: set wins
    regWrEn = 1; regAddr = 5'd1; regWdata = 32'h0000_0100;
    setValid = 1; setIdx = 8'd40;
    tick();
    regWrEn = 0; setValid = 0; regWdata = '0;
    expectRead(5'd1, 32'h0000_0100, "R3 set wins over same-cycle clear");
    clearVec(40);
    expectRead(5'd1, 32'h0, "R3 clear alone");

    // R9 high half
    regWrite(5'd16, 32'h0000_0004);
    setVec(200);
    expectLine(8'h80, "R9 high half vector 200");
    regWrite(5'd16, 32'h0000_0000);
    expectLine(8'h08, "R9 low half vector 200");
    clearVec(200);

    // R10 legacy group at index 5 -> vectors 40..47 (word 1 bits 8..15)
    regWrite(5'd16, 32'h0500_0000);
    expectRead(5'd16, 32'h0500_0000, "R11 legacy index readback");
    nmiIn = 1; tick(); nmiIn = 0;
    expectRead(5'd1, 32'h0000_0200, "R10 NMI to vector 41");
    expectLine(8'h01, "R10 NMI routed to line 0");
    clearVec(41);
    intdIn = 1; smiIn = 1; tick(); intdIn = 0; smiIn = 0;
    expectRead(5'd1, 32'h0000_8100, "R10 INTD to 47 and SMI to 40");
    regWrite(5'd1, 32'hFFFF_FFFF);
    initIn = 1; intaIn = 1; intbIn = 1; intcIn = 1; tick();
    initIn = 0; intaIn = 0; intbIn = 0; intcIn = 0;
    expectRead(5'd1, 32'h0000_7400, "R10 INIT INTA INTB INTC, position 3 empty");
    regWrite(5'd1, 32'hFFFF_FFFF);

    // R11 control readback and unmapped address
    regWrite(5'd16, 32'hFFFF_FFFF);
    expectRead(5'd16, 32'h1F00_0007, "R11 control field mask");
    expectRead(5'd17, 32'h0, "R11 unmapped address reads zero");
    expectRead(5'd31, 32'h0, "R11 top address reads zero");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule